// File: doc/BRIEF.md
# Firmware hub read target

This block is the memory-side responder on a 4-bit multiplexed firmware hub bus. It supports single-byte memory reads only. It watches an active-low frame strobe and a 4-bit bus. When it recognises a start nibble, it counts the clocks of the read cycle. It compares the device-select nibble against its strap pins and gathers a 28-bit address. It then checks the size nibble. After that it takes over the bus, sends a ready-sync nibble and returns one data byte as two nibbles. Last, it drives all ones and releases the bus to the host.

The byte comes from a local memory read port. A request carries the address, and its `mem_req_valid` / `mem_req_ready` pair follows the usual handshake rules:
- Once valid is raised, valid and the address stay unchanged until a clock edge sees ready high.
- The memory may hold ready low for as long as it needs.

The response is a one-cycle `mem_rsp_valid` pulse with the data byte. It has no ready signal, because the block always accepts a response. For the byte to reach the bus, the response must be sampled no later than the edge that ends clock 13. A later response is dropped, and the block sends 0xFF in its place. The request must also be accepted before the address of the next read cycle is complete.

Clock numbering: clock 1 is the bus clock in which the start nibble is sampled. Clock k is the k-th bus clock counted from there.

Top module: `fwh_read_target`

## Requirements
- R1: A start is recognised only in a clock where `frame_n` is low and the bus carries 1101. The nibble 1101 with `frame_n` high has no effect, and no output enable follows it.
- R2: When consecutive clocks with `frame_n` low carry 1101, the last of them is clock 1. The first clock with `frame_n` high is clock 2.
- R3: The block responds only if the clock-2 nibble equals `strap_id`. On a mismatch, `bus_oe` stays low for the rest of that cycle.
- R4: Clocks 3 to 9 carry the address, one nibble per clock, address bits 27:24 first and bits 3:0 last. The request presents exactly this address on `mem_req_addr`.
- R5: The clock-10 size nibble must be 0000. Any other value ends the cycle, and `bus_oe` stays low.
- R6: `mem_req_valid` rises in clock 10. While ready is low, valid and `mem_req_addr` stay unchanged, and valid drops after the accepting edge.
- R7: `bus_oe` is high only in clocks 12 to 16. In clock 12 the block drives 1111.
- R8: In clock 13 the block drives the ready-sync nibble 0000.
- R9: Clock 14 carries data bits 3:0 and clock 15 carries data bits 7:4.
- R10: Clock 16 drives 1111. In clock 17 `bus_oe` is low again.
- R11: A response that has not been sampled by the end of clock 13 is ignored. Clocks 14 and 15 then both carry 1111.
- R12: In any clock after clock 1, `frame_n` low with a nibble other than 1101 abandons the cycle. `bus_oe` then stays low until the next valid start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| bus_in | input | 4 | Nibble read from the shared bus |
| bus_out | output | 4 | Nibble the block drives |
| bus_oe | output | 1 | High while the block owns the bus |
| strap_id | input | 4 | Device-select strap value |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 28 | Byte address of the request |
| mem_rsp_valid | input | 1 | One-cycle pulse: read data present |
| mem_rsp_data | input | 8 | Read data byte |

## Verification
The bus output enable and nibbles come straight from the clock counter. If that counter is off, the fault shows at the ports within one clock: ownership moves a clock early or late, or the sync nibble lands in the wrong slot. A wrong address shift shows as soon as the request handshake happens, well before any data is sent. A wrong capture-window or data-valid flag does not show until clocks 14 and 15, where a correct byte turns into 1111 or the reverse. The bench therefore covers both on-time and late memory responses.

// File: rtl/fwh_read_pkg.sv
package fwh_read_pkg;
  localparam int NIB_W = 4;
  localparam logic [NIB_W-1:0] NIB_START = 4'b1101;
  localparam logic [NIB_W-1:0] NIB_ONE_BYTE = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_SYNC = 4'b0000;
  localparam logic [NIB_W-1:0] NIB_ONES = 4'b1111;

  // phase value = number of the bus clock most recently sampled (0 = idle)
  typedef logic [4:0] clk_idx_t;

  typedef struct packed {
    logic              oe;
    logic [NIB_W-1:0]  nib;
  } drive_t;
endpackage

// File: rtl/fwh_frame_tracker.sv
module fwh_frame_tracker
  import fwh_read_pkg::*;
#(
  parameter int ADDR_NIBS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] bus_in,
  input  logic [NIB_W-1:0] strap_id,
  output clk_idx_t         phase,
  output logic             addr_en,
  output logic             addr_done,
  output logic             rsp_window
);
  localparam int PH_ID        = 1;
  localparam int PH_ADDR_LAST = PH_ID + ADDR_NIBS;
  localparam int PH_SIZE      = PH_ADDR_LAST + 1;
  localparam int PH_WIN_LAST  = PH_SIZE + 3;
  localparam int PH_END       = PH_SIZE + 7;

  clk_idx_t phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!frame_n) begin
      phase_q <= (bus_in == NIB_START) ? clk_idx_t'(1) : '0;
    end else if (phase_q == '0) begin
      phase_q <= '0;
    end else if (phase_q == clk_idx_t'(PH_ID)) begin
      phase_q <= (bus_in == strap_id) ? clk_idx_t'(PH_ID + 1) : '0;
    end else if (phase_q == clk_idx_t'(PH_SIZE)) begin
      phase_q <= (bus_in == NIB_ONE_BYTE) ? clk_idx_t'(PH_SIZE + 1) : '0;
    end else if (phase_q >= clk_idx_t'(PH_END)) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + clk_idx_t'(1);
    end
  end

  assign phase      = phase_q;
  assign addr_en    = frame_n && (phase_q > clk_idx_t'(PH_ID)) &&
                      (phase_q <= clk_idx_t'(PH_ADDR_LAST));
  assign addr_done  = frame_n && (phase_q == clk_idx_t'(PH_ADDR_LAST));
  assign rsp_window = (phase_q >= clk_idx_t'(PH_SIZE)) &&
                      (phase_q <= clk_idx_t'(PH_WIN_LAST));

  assert_start_seen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && bus_in == NIB_START) |=> phase_q == clk_idx_t'(1));
  assert_id_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && phase_q == clk_idx_t'(PH_ID) && bus_in != strap_id) |=> phase_q == '0);
  assert_size_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && phase_q == clk_idx_t'(PH_SIZE) && bus_in != NIB_ONE_BYTE) |=> phase_q == '0);
  assert_abandon_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && bus_in != NIB_START) |=> phase_q == '0);
endmodule

// File: rtl/fwh_addr_collector.sv
module fwh_addr_collector
  import fwh_read_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_en,
  input  logic              addr_done,
  input  logic [NIB_W-1:0]  bus_in,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr
);
  localparam int SH_W = ADDR_W - NIB_W;

  logic [SH_W-1:0]   sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic              valid_q;
  logic              can_load;

  assign can_load = !valid_q || req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (addr_en && !addr_done) begin
      sh_q <= {sh_q[SH_W-NIB_W-1:0], bus_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else if (addr_done && can_load) begin
      addr_q  <= {sh_q, bus_in};
      valid_q <= 1'b1;
    end else if (valid_q && req_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign req_valid = valid_q;
  assign req_addr  = addr_q;

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !req_ready) |=> (valid_q && $stable(addr_q)));
endmodule

// File: rtl/fwh_rsp_holder.sv
module fwh_rsp_holder #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic              new_cycle,
  input  logic              window,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] data,
  output logic              data_ok
);
  logic              pending_q;
  logic              ok_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
    end else if (req_fire) begin
      pending_q <= 1'b1;
    end else if (rsp_valid) begin
      pending_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ok_q   <= 1'b0;
      data_q <= '0;
    end else if (new_cycle) begin
      ok_q <= 1'b0;
    end else if (rsp_valid && pending_q && window) begin
      ok_q   <= 1'b1;
      data_q <= rsp_data;
    end
  end

  assign data    = data_q;
  assign data_ok = ok_q;

  assert_late_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> $past(window));
endmodule

// File: rtl/fwh_bus_driver.sv
module fwh_bus_driver
  import fwh_read_pkg::*;
#(
  parameter int ADDR_NIBS = 7,
  parameter int DATA_W    = 8
) (
  input  clk_idx_t          phase,
  input  logic [DATA_W-1:0] data,
  input  logic              data_ok,
  output logic              oe,
  output logic [NIB_W-1:0]  nib
);
  localparam int PH_SIZE  = 2 + ADDR_NIBS;
  localparam int PH_TAKE  = PH_SIZE + 2;
  localparam int PH_SYNC  = PH_TAKE + 1;
  localparam int PH_DLO   = PH_SYNC + 1;
  localparam int PH_DHI   = PH_DLO + 1;
  localparam int PH_GIVE  = PH_DHI + 1;

  logic [DATA_W-1:0] byte_out;
  drive_t            drv;

  assign byte_out = data_ok ? data : {DATA_W{1'b1}};

  always_comb begin
    drv = '{oe: 1'b0, nib: NIB_ONES};
    if (phase == clk_idx_t'(PH_TAKE)) begin
      drv = '{oe: 1'b1, nib: NIB_ONES};
    end else if (phase == clk_idx_t'(PH_SYNC)) begin
      drv = '{oe: 1'b1, nib: NIB_SYNC};
    end else if (phase == clk_idx_t'(PH_DLO)) begin
      drv = '{oe: 1'b1, nib: byte_out[NIB_W-1:0]};
    end else if (phase == clk_idx_t'(PH_DHI)) begin
      drv = '{oe: 1'b1, nib: byte_out[2*NIB_W-1:NIB_W]};
    end else if (phase == clk_idx_t'(PH_GIVE)) begin
      drv = '{oe: 1'b1, nib: NIB_ONES};
    end
  end

  assign oe  = drv.oe;
  assign nib = drv.nib;
endmodule

// File: rtl/fwh_read_target.sv
module fwh_read_target
  import fwh_read_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        bus_in,
  output logic [3:0]        bus_out,
  output logic              bus_oe,
  input  logic [3:0]        strap_id,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int ADDR_NIBS = ADDR_W / NIB_W;

  clk_idx_t          phase;
  logic              addr_en;
  logic              addr_done;
  logic              rsp_window;
  logic              req_fire;
  logic [DATA_W-1:0] data;
  logic              data_ok;

  fwh_frame_tracker #(.ADDR_NIBS(ADDR_NIBS)) u_track (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
    .strap_id(strap_id), .phase(phase), .addr_en(addr_en),
    .addr_done(addr_done), .rsp_window(rsp_window)
  );

  fwh_addr_collector #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr_en(addr_en), .addr_done(addr_done),
    .bus_in(bus_in), .req_ready(mem_req_ready), .req_valid(mem_req_valid),
    .req_addr(mem_req_addr)
  );

  assign req_fire = mem_req_valid && mem_req_ready;

  fwh_rsp_holder #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .new_cycle(addr_done),
    .window(rsp_window), .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
    .data(data), .data_ok(data_ok)
  );

  fwh_bus_driver #(.ADDR_NIBS(ADDR_NIBS), .DATA_W(DATA_W)) u_drv (
    .phase(phase), .data(data), .data_ok(data_ok), .oe(bus_oe), .nib(bus_out)
  );

  assert_take_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> bus_out == NIB_ONES);
  assert_sync_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |=> (bus_oe && bus_out == NIB_SYNC));
  assert_release_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |-> $past(bus_out) == NIB_ONES);
endmodule

// File: tb/test_fwh_read_target.sv
module test_fwh_read_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  bus_in = 4'hF;
  logic [3:0]  bus_out;
  logic        bus_oe;
  logic [3:0]  strap_id = 4'h6;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [27:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = 8'h00;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int stall = 0;
  int lat = 1;
  logic [27:0] exp_addr = '0;

  typedef struct {
    logic       oe;
    logic [3:0] nib;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  fwh_read_target i_fwh_read_target (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .strap_id(strap_id),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [7:0] mem_byte(logic [27:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(logic fr, logic [3:0] nib, logic eoe, logic [3:0] enib, string tag);
    @(negedge clk);
    frame_n = fr;
    bus_in  = nib;
    q.push_back('{eoe, enib, tag});
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) tick(1'b1, 4'hF, 1'b0, 4'h0, tag);
  endtask

  task automatic xact(int nstarts, logic start_fr, logic [3:0] idv, logic [27:0] a,
                      logic [3:0] sz, bit drv, bit late, string tag);
    logic [7:0] d;
    string dtag;
    d = late ? 8'hFF : mem_byte(a);
    dtag = late ? "R11" : "R9";
    exp_addr = a;
    for (int i = 0; i < nstarts; i++) tick(start_fr, 4'b1101, 1'b0, 4'h0, tag);
    tick(1'b1, idv, 1'b0, 4'h0, tag);
    for (int n = 0; n < 7; n++) tick(1'b1, a[27-4*n -: 4], 1'b0, 4'h0, tag);
    tick(1'b1, sz, 1'b0, 4'h0, tag);
    tick(1'b1, 4'hF, 1'b0, 4'h0, tag);
    tick(1'b1, 4'hF, drv, 4'hF, drv ? "R7" : tag);
    tick(1'b1, 4'hF, drv, 4'h0, drv ? "R8" : tag);
    tick(1'b1, 4'hF, drv, d[3:0], drv ? dtag : tag);
    tick(1'b1, 4'hF, drv, d[7:4], drv ? dtag : tag);
    tick(1'b1, 4'hF, drv, 4'hF, drv ? "R10" : tag);
    tick(1'b1, 4'hF, 1'b0, 4'h0, "R10");
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(bus_oe == e.oe, e.tag, "bus_oe", int'(bus_oe), int'(e.oe));
        if (e.oe) check(bus_out == e.nib, e.tag, "bus_out", int'(bus_out), int'(e.nib));
      end
    end
  end

  // memory model
  initial begin
    int st;
    int cnt;
    logic [27:0] got;
    st = 0; cnt = 0; got = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        check(mem_req_addr == exp_addr, "R4", "mem_req_addr", int'(mem_req_addr), int'(exp_addr));
        got = mem_req_addr;
        cnt = lat;
        st = 2;
      end else if (st == 0 && mem_req_valid) begin
        cnt = stall;
        st = 1;
      end
      if (st == 1) begin
        if (cnt == 0) begin
          mem_req_ready = 1'b1;
          st = 3;
        end else begin
          cnt--;
          check(mem_req_valid == 1'b1, "R6", "valid held", int'(mem_req_valid), 1);
        end
      end
      if (st == 2) begin
        cnt--;
        if (cnt <= 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_byte(got);
          st = 0;
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bus_oe == 1'b0, "R7", "reset bus_oe", int'(bus_oe), 0);
    check(mem_req_valid == 1'b0, "R6", "reset req_valid", int'(mem_req_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2, "R1");

    // R9: plain read, prompt memory
    stall = 0; lat = 1;
    xact(1, 1'b0, 4'h6, 28'h1234567, 4'h0, 1'b1, 1'b0, "R9");
    // R1: 1101 with frame high is no start
    xact(1, 1'b1, 4'h6, 28'h0ABCDEF, 4'h0, 1'b0, 1'b0, "R1");
    // R2: repeated starts, last one counts
    xact(3, 1'b0, 4'h6, 28'hFEDCBA9, 4'h0, 1'b1, 1'b0, "R2");
    // R3: ID mismatch
    xact(1, 1'b0, 4'h5, 28'h0000111, 4'h0, 1'b0, 1'b0, "R3");
    // R5: unsupported size
    xact(1, 1'b0, 4'h6, 28'h2222333, 4'h1, 1'b0, 1'b0, "R5");
    idle(3, "R5");
    // R6: stalled handshake still on time
    stall = 1; lat = 2;
    xact(1, 1'b0, 4'h6, 28'h3141592, 4'h0, 1'b1, 1'b0, "R6");
    // R11: response too late
    stall = 0; lat = 4;
    xact(1, 1'b0, 4'h6, 28'h2718281, 4'h0, 1'b1, 1'b1, "R11");
    idle(3, "R11");
    // R12: abandon mid address
    stall = 0; lat = 1;
    tick(1'b0, 4'b1101, 1'b0, 4'h0, "R12");
    tick(1'b1, 4'h6, 1'b0, 4'h0, "R12");
    tick(1'b1, 4'h1, 1'b0, 4'h0, "R12");
    tick(1'b1, 4'h2, 1'b0, 4'h0, "R12");
    tick(1'b0, 4'h0, 1'b0, 4'h0, "R12");
    idle(16, "R12");
    // back-to-back reads after abandon, different strap
    strap_id = 4'hA;
    xact(1, 1'b0, 4'hA, 28'h00000FF, 4'h0, 1'b1, 1'b0, "R4");
    xact(1, 1'b0, 4'hA, 28'hC0FFEE1, 4'h0, 1'b1, 1'b0, "R9");
    idle(4, "R10");
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule